// File: doc/BRIEF.md
# SPI Receive Byte Queue with Level Threshold

This block sits between the receive shift register of an SPI peripheral and its register-read path. Each completed frame, 8 or 16 bits wide, is pushed into a small byte-organised queue (four bytes by default). A 16-bit frame takes two byte slots, low byte first. Software or a DMA engine pops the queue one byte or one halfword at a time. The oldest byte always lands in bits [7:0] of the read data.

The receive-ready flag does not mean "not empty". It follows a programmable level: either a quarter of the capacity (enough for a byte read) or half of it (enough for a halfword read). When a frame arrives and does not fit, the frame is dropped, the stored bytes stay as they are, and a sticky overrun flag is raised. The flag holds until an explicit clear. When CRC mode is on, the queue behaves as a one-frame holding buffer. Two interrupt requests are produced from the flags and their enables.

Top module: `spi_rx_fifo`

## Requirements
- R1: With `thr_quarter` = 1, `rx_ne` is 1 after the clock edge at which the occupancy becomes at least one byte.
- R2: With `thr_quarter` = 0, `rx_ne` is 1 only while the occupancy is at least two bytes. One stored byte leaves it at 0.
- R3: `rx_ne` returns to 0 at the clock edge at which a read, or a threshold change, makes its level condition false. No software action is needed.
- R4: `rx_irq` equals `rx_ne` AND `rx_ie`, registered. It updates at the same edge as `rx_ne`.
- R5: A frame that needs more bytes than are free is discarded. This is judged against the occupancy before any same-cycle read. The stored bytes and their order are unchanged, and `ovr` is set at that edge.
- R6: `ovr` stays 1 until an `ovr_clr` strobe. If an overrun and `ovr_clr` occur in the same cycle, `ovr` stays 1.
- R7: `err_irq` equals `ovr` AND `err_ie`, registered.
- R8: While `crc_mode` = 1, a frame is accepted only when the queue is empty. Any frame arriving while data is held is an overrun.
- R9: A read of an empty queue returns 0 and changes no state.
- R10: Frame bits [7:0] are stored before bits [15:8], selected by `rx_wide` = 1. A read with `rd_wide` = 0 returns the oldest byte in [7:0] with [15:8] = 0. A read with `rd_wide` = 1 returns the oldest byte in [7:0] and the next in [15:8]. A byte that is not present reads as 0 and is not popped. `rd_data` updates at the edge after `rd_en` and holds otherwise.
- R11: A synchronous `rst` = 1 empties the queue and drives `rx_ne`, `ovr`, `rx_irq`, `err_irq` and `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Strobe: a received frame is offered |
| rx_wide | input | 1 | 1 = 16-bit frame, 0 = 8-bit frame |
| rx_data | input | 16 | Received frame, low byte in [7:0] |
| rd_en | input | 1 | Read strobe |
| rd_wide | input | 1 | 1 = halfword read, 0 = byte read |
| rd_data | output | 16 | Data of the last read |
| thr_quarter | input | 1 | 1 = quarter-level threshold, 0 = half-level threshold |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| crc_mode | input | 1 | 1 = single-frame buffer behaviour |
| ovr_clr | input | 1 | Strobe that clears the overrun flag |
| rx_ne | output | 1 | Receive level reached |
| ovr | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
A wrong occupancy count shows up at the next edge in one of two ways. Either `rx_ne` disagrees with the chosen level, or the overrun decision for the next frame is wrong. A wrong read or write pointer stays hidden until the affected byte is read. It then shows up as a swapped or stale byte in `rd_data`, one cycle after that read. Because of this, every stimulus that stores data is followed by reads that drain the queue completely, ending with a read of the empty queue. Dropped frames and the single-buffer CRC case are checked the same way.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  typedef enum logic {
    LVL_HALF    = 1'b0,
    LVL_QUARTER = 1'b1
  } lvl_sel_e;

  function automatic int unsigned quarter_of(input int unsigned depth);
    return (depth / 4 < 1) ? 1 : depth / 4;
  endfunction
endpackage

// File: rtl/spi_rx_store.sv
module spi_rx_store #(
  parameter int unsigned BW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned FW   = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic          wr_wide,
  input  logic [FW-1:0] wr_data,
  input  logic          single_buf,
  input  logic          rd_en,
  input  logic          rd_wide,
  output logic [FW-1:0] rd_data,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          ovr_evt
);
  logic [BW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] need, req, pop;
  logic [CW:0]   fill_sum;
  logic          space_ok, accept;
  logic [BW-1:0] b0, b1;

  always_comb begin
    need     = wr_wide ? CW'(2) : CW'(1);
    fill_sum = {1'b0, cnt} + {1'b0, need};
    space_ok = single_buf ? (cnt == '0) : (fill_sum <= (CW+1)'(DEPTH));
    accept   = wr_valid & space_ok;
    ovr_evt  = wr_valid & ~space_ok;
    req      = rd_en ? (rd_wide ? CW'(2) : CW'(1)) : '0;
    pop      = (req > cnt) ? cnt : req;
    cnt_nxt  = cnt - pop + (accept ? need : '0);
    b0       = (cnt != '0) ? mem[rp] : '0;
    b1       = (rd_wide && cnt >= CW'(2)) ? mem[rp + AW'(1)] : '0;
  end

  // byte storage: no reset, so it can map onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (accept) begin
      mem[wp] <= wr_data[BW-1:0];
      if (wr_wide) mem[wp + AW'(1)] <= wr_data[FW-1:BW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      rd_data <= '0;
    end else begin
      if (accept) wp <= wp + AW'(need);
      rp  <= rp + AW'(pop);
      cnt <= cnt_nxt;
      if (rd_en) rd_data <= {b1, b0};
    end
  end

  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  assert_drop_keeps_level_R5: assert property (@(posedge clk) disable iff (rst)
    ovr_evt && !rd_en |=> cnt == $past(cnt));

  assert_empty_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en && cnt == '0 && !wr_valid |=> rd_data == '0 && cnt == '0);
endmodule

// File: rtl/spi_rx_flags.sv
module spi_rx_flags
  import spi_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned QLVL = quarter_of(DEPTH),
  localparam int unsigned HLVL = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          lvl_sel,
  input  logic          rx_ie,
  input  logic          err_ie,
  input  logic          ovr_evt,
  input  logic          ovr_clr,
  output logic          rx_ne,
  output logic          ovr,
  output logic          rx_irq,
  output logic          err_irq
);
  lvl_sel_e lvl;
  logic     ne_nxt, ovr_nxt;

  always_comb begin
    lvl     = lvl_sel_e'(lvl_sel);
    ne_nxt  = (lvl == LVL_QUARTER) ? (cnt_nxt >= CW'(QLVL)) : (cnt_nxt >= CW'(HLVL));
    ovr_nxt = ovr_evt | (ovr & ~ovr_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ne   <= 1'b0;
      ovr     <= 1'b0;
      rx_irq  <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      rx_ne   <= ne_nxt;
      ovr     <= ovr_nxt;
      rx_irq  <= ne_nxt & rx_ie;
      err_irq <= ovr_nxt & err_ie;
    end
  end

  assert_clear_drops_ovr_R6: assert property (@(posedge clk) disable iff (rst)
    ovr_clr && !ovr_evt |=> !ovr);

  assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    ovr && !ovr_clr |=> ovr);

  assert_rx_irq_needs_ne_R4: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_ne);

  assert_err_irq_needs_ovr_R7: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> ovr);
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned DEPTH_BYTES = 4,
  localparam int unsigned FW         = 2 * BYTE_W,
  localparam int unsigned CW         = $clog2(DEPTH_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic          rx_wide,
  input  logic [FW-1:0] rx_data,
  input  logic          rd_en,
  input  logic          rd_wide,
  output logic [FW-1:0] rd_data,
  input  logic          thr_quarter,
  input  logic          rx_ie,
  input  logic          err_ie,
  input  logic          crc_mode,
  input  logic          ovr_clr,
  output logic          rx_ne,
  output logic          ovr,
  output logic          rx_irq,
  output logic          err_irq
);
  logic [CW-1:0] cnt, cnt_nxt;
  logic          ovr_evt;

  spi_rx_store #(.BW(BYTE_W), .DEPTH(DEPTH_BYTES)) u_store (
    .clk(clk), .rst(rst),
    .wr_valid(rx_valid), .wr_wide(rx_wide), .wr_data(rx_data),
    .single_buf(crc_mode),
    .rd_en(rd_en), .rd_wide(rd_wide), .rd_data(rd_data),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .ovr_evt(ovr_evt)
  );

  spi_rx_flags #(.DEPTH(DEPTH_BYTES)) u_flags (
    .clk(clk), .rst(rst),
    .cnt_nxt(cnt_nxt), .lvl_sel(thr_quarter),
    .rx_ie(rx_ie), .err_ie(err_ie),
    .ovr_evt(ovr_evt), .ovr_clr(ovr_clr),
    .rx_ne(rx_ne), .ovr(ovr), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  assert_crc_second_frame_ovr_R8: assert property (@(posedge clk) disable iff (rst)
    crc_mode && rx_valid && cnt != '0 |=> ovr);
endmodule

// File: tb/spi_rx_fifo_test.sv
module spi_rx_fifo_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, rx_wide = 0, rd_en = 0, rd_wide = 0;
  logic [15:0] rx_data = '0;
  logic thr_quarter = 1, rx_ie = 1, err_ie = 1, crc_mode = 0, ovr_clr = 0;
  logic [15:0] rd_data;
  logic rx_ne, ovr, rx_irq, err_irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  spi_rx_fifo uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_wide(rx_wide), .rx_data(rx_data),
    .rd_en(rd_en), .rd_wide(rd_wide), .rd_data(rd_data),
    .thr_quarter(thr_quarter), .rx_ie(rx_ie), .err_ie(err_ie), .crc_mode(crc_mode),
    .ovr_clr(ovr_clr), .rx_ne(rx_ne), .ovr(ovr), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  // {wv, ww, wd[15:0], rv, rw, thr, exp_ne, exp_ovr, chk_rd, exp_rd[15:0]}
  localparam int NV = 10;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1,1'b0,16'h0011, 1'b0,1'b0, 1'b1, 1'b1,1'b0, 1'b0,16'h0000}, // R1 one byte, quarter
    {1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b0, 1'b0,1'b0, 1'b0,16'h0000}, // R2/R3 half level, one byte
    {1'b1,1'b1,16'h3322, 1'b0,1'b0, 1'b0, 1'b1,1'b0, 1'b0,16'h0000}, // R2 three bytes
    {1'b1,1'b0,16'h0044, 1'b0,1'b0, 1'b0, 1'b1,1'b0, 1'b0,16'h0000}, // full
    {1'b1,1'b0,16'h0055, 1'b0,1'b0, 1'b0, 1'b1,1'b1, 1'b0,16'h0000}, // R5 overrun
    {1'b0,1'b0,16'h0000, 1'b1,1'b1, 1'b0, 1'b1,1'b1, 1'b1,16'h2211}, // R10 halfword
    {1'b0,1'b0,16'h0000, 1'b1,1'b0, 1'b0, 1'b0,1'b1, 1'b1,16'h0033}, // R3 drop below half
    {1'b1,1'b1,16'h6655, 1'b1,1'b0, 1'b1, 1'b1,1'b1, 1'b1,16'h0044}, // push+pop same cycle
    {1'b0,1'b0,16'h0000, 1'b1,1'b1, 1'b1, 1'b0,1'b1, 1'b1,16'h6655}, // R10 wide frame order
    {1'b0,1'b0,16'h0000, 1'b1,1'b1, 1'b1, 1'b0,1'b1, 1'b1,16'h0000}  // R9 empty read
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic wv, input logic ww, input logic [15:0] wd,
                    input logic rv, input logic rw);
    rx_valid = wv; rx_wide = ww; rx_data = wd; rd_en = rv; rd_wide = rw;
    @(negedge clk);
    rx_valid = 0; rx_wide = 0; rd_en = 0; rd_wide = 0; ovr_clr = 0;
  endtask

  task automatic idle();
    op(0, 0, 16'h0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R11 reset rx_ne", {15'b0, rx_ne}, 16'h0);
    chk("R11 reset ovr", {15'b0, ovr}, 16'h0);
    chk("R11 reset irqs", {14'b0, rx_irq, err_irq}, 16'h0);
    chk("R11 reset rd_data", rd_data, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      thr_quarter = v[19];
      op(v[39], v[38], v[37:22], v[21], v[20]);
      chk($sformatf("R1/R2/R3 rx_ne vec%0d", i), {15'b0, rx_ne}, {15'b0, v[18]});
      chk($sformatf("R5/R6 ovr vec%0d", i), {15'b0, ovr}, {15'b0, v[17]});
      chk($sformatf("R4/R7 irqs vec%0d", i), {14'b0, rx_irq, err_irq}, {14'b0, v[18], v[17]});
      if (v[16]) chk($sformatf("R10 rd_data vec%0d", i), rd_data, v[15:0]);
    end

    // R6 clear
    ovr_clr = 1; idle();
    chk("R6 clear ovr", {15'b0, ovr}, 16'h0);
    chk("R7 err_irq drops", {15'b0, err_irq}, 16'h0);

    // R10 partial halfword read
    op(1, 0, 16'h0077, 0, 0);
    op(0, 0, 16'h0, 1, 1);
    chk("R10 partial wide read", rd_data, 16'h0077);
    chk("R3 rx_ne after drain", {15'b0, rx_ne}, 16'h0);
    op(0, 0, 16'h0, 1, 0);
    chk("R9 empty byte read", rd_data, 16'h0000);

    // R5 wide frame into one free byte, with clear in same cycle (R6)
    op(1, 0, 16'h00A1, 0, 0);
    op(1, 1, 16'hA3A2, 0, 0);
    ovr_clr = 1;
    op(1, 1, 16'hB2B1, 0, 0);
    chk("R6 set wins over clear", {15'b0, ovr}, 16'h1);
    op(0, 0, 16'h0, 1, 1);
    chk("R5 contents kept lo", rd_data, 16'hA2A1);
    op(0, 0, 16'h0, 1, 0);
    chk("R5 contents kept hi", rd_data, 16'h00A3);
    op(0, 0, 16'h0, 1, 1);
    chk("R5 dropped frame absent", rd_data, 16'h0000);

    // R4 / R7 enables
    rx_ie = 0; err_ie = 0;
    op(1, 0, 16'h005A, 0, 0);
    chk("R4 rx_ne with ie off", {15'b0, rx_ne}, 16'h1);
    chk("R4 rx_irq masked", {15'b0, rx_irq}, 16'h0);
    chk("R7 err_irq masked", {15'b0, err_irq}, 16'h0);
    rx_ie = 1; err_ie = 1; idle();
    chk("R4 rx_irq enabled", {15'b0, rx_irq}, 16'h1);
    chk("R7 err_irq enabled", {15'b0, err_irq}, 16'h1);
    op(0, 0, 16'h0, 1, 0);
    chk("R4 rx_irq follows drain", {15'b0, rx_irq}, 16'h0);

    // R8 CRC single buffer
    ovr_clr = 1; idle();
    crc_mode = 1;
    op(1, 0, 16'h00C1, 0, 0);
    chk("R8 first frame held", {14'b0, rx_ne, ovr}, 16'h2);
    op(1, 0, 16'h00C2, 0, 0);
    chk("R8 second frame overrun", {15'b0, ovr}, 16'h1);
    op(0, 0, 16'h0, 1, 0);
    chk("R8 first frame read", rd_data, 16'h00C1);
    op(0, 0, 16'h0, 1, 0);
    chk("R8 second frame discarded", rd_data, 16'h0000);
    op(1, 1, 16'hD2D1, 0, 0);
    chk("R8 wide into empty", {14'b0, rx_ne, ovr}, 16'h3);
    op(0, 0, 16'h0, 1, 1);
    chk("R8 wide frame read", rd_data, 16'hD2D1);
    crc_mode = 0;

    // R11 reset with data present
    op(1, 1, 16'hE2E1, 0, 0);
    rst = 1; idle(); rst = 0;
    chk("R11 reset flags", {13'b0, rx_ne, ovr, rx_irq}, 16'h0);
    op(0, 0, 16'h0, 1, 1);
    chk("R11 reset empties", rd_data, 16'h0000);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule